// File: doc/BRIEF.md
# Split-Readout Line and Frame Timing Generator

This block produces the horizontal and vertical readout timing for an area sensor that delivers two pixels per pixel clock, one on each output channel. From a single pixel-rate clock it keeps a column counter and a line counter. It decodes them into a line-valid window, a frame-valid window and one-cycle start-of-line and start-of-frame strobes. The counter values also go to the downstream data path. With the default parameters a line is 1300 clocks, of which 1024 carry data, so one line yields 2048 samples. A frame is 2080 lines, of which 2048 are active. At a 40 MHz pixel clock this gives a 32.5 µs line and a frame of about 67.6 ms.

When the external-sync mode input is high, the counters are slaved to external HD and VD pulses. Each pulse goes through a two-flop synchronizer and a rising-edge detector. An HD edge restarts the column count and advances the line. A VD edge restarts the line count. Between edges, each counter stops at its last value and waits for the next edge.

In external-sync mode the block also measures, in pixel clocks, the time between consecutive rising edges of each input. If a measured interval falls outside its tolerance window, a sticky error flag is set. By default the HD window is ±0.2 % of the line length and the VD window is ±2 % of the frame length.

Top module: `readout_timing_gen`

## Requirements
- R1: With external sync off, the column counter counts 0 to H_TOTAL-1 and wraps. The line counter advances on each column wrap and itself wraps from V_TOTAL-1 to 0.
- R2: line_valid is high exactly when frame_valid is high and the column count is below H_ACTIVE.
- R3: frame_valid is high exactly on lines V_LEAD through V_LEAD+V_ACTIVE-1 (lines 3 to 2050 by default). At least three blank lines remain before the frame wraps.
- R4: line_strobe is high in each cycle where the column count is 0. frame_strobe is high in each cycle where the column and line counts are both 0.
- R5: With external sync on, a rising ext_hd does two things. The column count reads 0 after the third clock edge that samples ext_hd high, and the line count advances by one at the same time. Without an HD edge the column count holds at H_TOTAL-1.
- R6: With external sync on, the line count reads 0 after the third clock edge that samples a rising ext_vd. When HD edges arrive with no VD edge, the line count holds at V_TOTAL-1.
- R7: With external sync on, hd_err is set when two consecutive ext_hd rising edges are more than H_TOL clocks away from H_TOTAL clocks apart. An interval that differs by exactly H_TOL does not set it. Once set, only reset clears it.
- R8: With external sync on, vd_err is set when two consecutive ext_vd rising edges are more than V_TOL clocks away from H_TOTAL*V_TOTAL clocks apart. Once set, only reset clears it.
- R9: Reset clears both counters and both error flags, so the first cycle after reset is a start of frame.
- R10: With external sync off, activity on ext_hd and ext_vd changes neither the counters nor the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sync_en | input | 1 | Select external HD/VD locking |
| ext_hd | input | 1 | External line sync, asynchronous |
| ext_vd | input | 1 | External frame sync, asynchronous |
| col_cnt | output | $clog2(H_TOTAL) (11) | Pixel column within the line |
| line_cnt | output | $clog2(V_TOTAL) (12) | Line within the frame |
| line_strobe | output | 1 | Start of line |
| frame_strobe | output | 1 | Start of frame |
| line_valid | output | 1 | Active pixels of an active line |
| frame_valid | output | 1 | Active lines of the frame |
| hd_err | output | 1 | Sticky: HD interval out of tolerance |
| vd_err | output | 1 | Sticky: VD interval out of tolerance |

## Verification
The hardest case to reach from the ports is the edge of the tolerance windows. The interval counter only reports when the next edge arrives, and the flag is sticky. The stimulus therefore first sends a run of in-window HD intervals, including one that is exactly H_TOL long. It confirms the flag is still clear, then sends one interval one clock too long. It repeats the same approach for VD with a frame-length interval at exactly V_TOL. The bench uses a scaled-down geometry of 10-clock lines and 9-line frames, so that full frames and the counters' hold states are reached within a short run.

// File: rtl/readout_timing_gen.sv
module readout_timing_gen #(
  parameter int H_ACTIVE = 1024,
  parameter int H_TOTAL  = 1300,
  parameter int V_ACTIVE = 2048,
  parameter int V_LEAD   = 3,
  parameter int V_TOTAL  = 2080,
  parameter int H_TOL    = H_TOTAL / 500,
  parameter int V_TOL    = (H_TOTAL * V_TOTAL) / 50
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_sync_en,
  input  logic                       ext_hd,
  input  logic                       ext_vd,
  output logic [$clog2(H_TOTAL)-1:0] col_cnt,
  output logic [$clog2(V_TOTAL)-1:0] line_cnt,
  output logic                       line_strobe,
  output logic                       frame_strobe,
  output logic                       line_valid,
  output logic                       frame_valid,
  output logic                       hd_err,
  output logic                       vd_err
);

  localparam int CW      = $clog2(H_TOTAL);
  localparam int LW      = $clog2(V_TOTAL);
  localparam int F_TOTAL = H_TOTAL * V_TOTAL;
  localparam int HPW     = $clog2(H_TOTAL + H_TOL + 2) + 1;
  localparam int VPW     = $clog2(F_TOTAL + V_TOL + 2) + 1;

  logic [2:0] hd_s, vd_s;
  logic       hd_rise, vd_rise;
  logic       col_last, line_last;
  logic [HPW-1:0] hd_per;
  logic [VPW-1:0] vd_per;
  logic       hd_seen, vd_seen;
  logic       hd_bad, vd_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_s <= '0;
      vd_s <= '0;
    end else begin
      hd_s <= {hd_s[1:0], ext_hd};
      vd_s <= {vd_s[1:0], ext_vd};
    end
  end

  assign hd_rise   = hd_s[1] & ~hd_s[2];
  assign vd_rise   = vd_s[1] & ~vd_s[2];
  assign col_last  = (col_cnt == CW'(H_TOTAL - 1));
  assign line_last = (line_cnt == LW'(V_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_cnt  <= '0;
      line_cnt <= '0;
    end else if (ext_sync_en) begin
      if (hd_rise)        col_cnt <= '0;
      else if (!col_last) col_cnt <= col_cnt + 1'b1;
      if (vd_rise)                     line_cnt <= '0;
      else if (hd_rise && !line_last)  line_cnt <= line_cnt + 1'b1;
    end else begin
      col_cnt <= col_last ? '0 : col_cnt + 1'b1;
      if (col_last) line_cnt <= line_last ? '0 : line_cnt + 1'b1;
    end
  end

  assign frame_valid  = (line_cnt >= LW'(V_LEAD)) && (line_cnt < LW'(V_LEAD + V_ACTIVE));
  assign line_valid   = frame_valid && (col_cnt < CW'(H_ACTIVE));
  assign line_strobe  = (col_cnt == '0);
  assign frame_strobe = line_strobe && (line_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_per  <= '0;
      vd_per  <= '0;
      hd_seen <= 1'b0;
      vd_seen <= 1'b0;
    end else begin
      if (hd_rise)              hd_per <= HPW'(1);
      else if (hd_per != '1)    hd_per <= hd_per + 1'b1;
      if (vd_rise)              vd_per <= VPW'(1);
      else if (vd_per != '1)    vd_per <= vd_per + 1'b1;
      hd_seen <= hd_seen | hd_rise;
      vd_seen <= vd_seen | vd_rise;
    end
  end

  assign hd_bad = (hd_per > HPW'(H_TOTAL + H_TOL)) || (hd_per < HPW'(H_TOTAL - H_TOL));
  assign vd_bad = (vd_per > VPW'(F_TOTAL + V_TOL)) || (vd_per < VPW'(F_TOTAL - V_TOL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_err <= 1'b0;
      vd_err <= 1'b0;
    end else begin
      if (ext_sync_en && hd_rise && hd_seen && hd_bad) hd_err <= 1'b1;
      if (ext_sync_en && vd_rise && vd_seen && vd_bad) vd_err <= 1'b1;
    end
  end

  a_r1_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sync_en && col_last |=> col_cnt == '0);
  a_r1_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sync_en && !col_last |=> col_cnt == $past(col_cnt) + 1'b1);
  a_r2_lval_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid);
  a_r4_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> line_strobe);
  a_r5_hd_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_en && hd_rise |=> col_cnt == '0);
  a_r5_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_en && !hd_rise && col_last |=> $stable(col_cnt));
  a_r6_vd_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_en && vd_rise |=> line_cnt == '0);
  a_r7_hd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hd_err |=> hd_err);
  a_r8_vd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vd_err |=> vd_err);
  a_r10_no_err_free: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sync_en && !hd_err |=> !hd_err);

endmodule

// File: tb/tb_readout_timing_gen.sv
module tb_readout_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 6, HT = 10, VA = 4, VL = 2, VT = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sync_en = 1'b0, ext_hd = 1'b0, ext_vd = 1'b0;
  logic [3:0] col_cnt, line_cnt;
  logic line_strobe, frame_strobe, line_valid, frame_valid, hd_err, vd_err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  readout_timing_gen #(.H_ACTIVE(HA), .H_TOTAL(HT), .V_ACTIVE(VA), .V_LEAD(VL),
                       .V_TOTAL(VT), .H_TOL(1), .V_TOL(3)) dut (
    .clk(clk), .rst_n(rst_n), .ext_sync_en(ext_sync_en), .ext_hd(ext_hd), .ext_vd(ext_vd),
    .col_cnt(col_cnt), .line_cnt(line_cnt), .line_strobe(line_strobe),
    .frame_strobe(frame_strobe), .line_valid(line_valid), .frame_valid(frame_valid),
    .hd_err(hd_err), .vd_err(vd_err));

  // {sample index[15:0], col[7:0], line[7:0], lval, fval, lstrobe, fstrobe}
  localparam logic [35:0] VEC [11] = '{
    {16'd0,   8'd0, 8'd0, 4'b0011},
    {16'd5,   8'd5, 8'd0, 4'b0000},
    {16'd20,  8'd0, 8'd2, 4'b1110},
    {16'd25,  8'd5, 8'd2, 4'b1100},
    {16'd26,  8'd6, 8'd2, 4'b0100},
    {16'd39,  8'd9, 8'd3, 4'b0100},
    {16'd55,  8'd5, 8'd5, 4'b1100},
    {16'd60,  8'd0, 8'd6, 4'b0010},
    {16'd89,  8'd9, 8'd8, 4'b0000},
    {16'd90,  8'd0, 8'd0, 4'b0011},
    {16'd123, 8'd3, 8'd3, 4'b1100}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input logic ext);
    rst_n = 1'b0; ext_hd = 1'b0; ext_vd = 1'b0; ext_sync_en = ext;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse(input logic h, input logic v, input int len);
    ext_hd = h; ext_vd = v;
    step();
    ext_hd = 1'b0; ext_vd = 1'b0;
    repeat (len - 1) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    // R9 reset state
    do_reset(1'b0);
    chk("R9 col", col_cnt, 0); chk("R9 line", line_cnt, 0);
    chk("R9 hd_err", hd_err, 0); chk("R9 vd_err", vd_err, 0);
    // R1 R2 R3 R4 free run table; R10 ext pins toggle while ignored
    k = 0;
    for (int i = 0; i < 11; i++) begin
      while (k < int'(VEC[i][35:20])) begin
        ext_hd = (k % 7 == 3); ext_vd = (k % 11 == 5);
        step(); k++;
      end
      chk("R1 col", col_cnt, int'(VEC[i][19:12]));
      chk("R1 line", line_cnt, int'(VEC[i][11:4]));
      chk("R2 line_valid", line_valid, int'(VEC[i][3]));
      chk("R3 frame_valid", frame_valid, int'(VEC[i][2]));
      chk("R4 line_strobe", line_strobe, int'(VEC[i][1]));
      chk("R4 frame_strobe", frame_strobe, int'(VEC[i][0]));
    end
    chk("R10 hd_err", hd_err, 0); chk("R10 vd_err", vd_err, 0);

    // R5 external HD lock and hold
    do_reset(1'b1);
    repeat (15) step();
    chk("R5 col hold", col_cnt, 9); chk("R5 line hold", line_cnt, 0);
    ext_hd = 1'b1;
    step(); step();
    chk("R5 latency col", col_cnt, 9);
    step();
    chk("R5 col reset", col_cnt, 0); chk("R5 line adv", line_cnt, 1);
    ext_hd = 1'b0;
    repeat (7) step();
    repeat (3) pulse(1'b1, 1'b0, 10);
    chk("R5 line count", line_cnt, 4); chk("R5 col", col_cnt, 7);
    // R7 tolerance boundary
    pulse(1'b1, 1'b0, 11); pulse(1'b1, 1'b0, 11); pulse(1'b1, 1'b0, 12);
    chk("R7 at tolerance", hd_err, 0);
    pulse(1'b1, 1'b0, 10);
    chk("R7 out of range", hd_err, 1);
    pulse(1'b1, 1'b0, 10); pulse(1'b1, 1'b0, 10);
    chk("R7 sticky", hd_err, 1);
    chk("R6 line hold", line_cnt, 8);

    // R6 R8 external VD lock and window
    do_reset(1'b1);
    repeat (3) pulse(1'b1, 1'b0, 10);
    chk("R6 line before", line_cnt, 3);
    ext_vd = 1'b1;
    step(); step();
    chk("R6 latency", line_cnt, 3);
    step();
    chk("R6 line reset", line_cnt, 0);
    ext_vd = 1'b0;
    repeat (87) step();
    pulse(1'b0, 1'b1, 93); pulse(1'b0, 1'b1, 94);
    chk("R8 at tolerance", vd_err, 0);
    pulse(1'b0, 1'b1, 10);
    chk("R8 out of range", vd_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule